// File: doc/BRIEF.md
# Iterative 32-bit normalizer

This unit takes a 32-bit accumulator word and moves it left, one bit position per clock, until a 1 sits in the top bit. When it finishes it presents the shifted word and an 8-bit count of the positions it moved. The caller pulses `start_i` with the operand on `operand_i`. The unit then raises `busy_o`, works through the shifts, and marks the end with a single-cycle `done_o`. At that point the normalized word and the count are valid on `result_o` and `shift_cnt_o`. Both hold their values until the next operation finishes.

The latency depends on the data and follows a fixed formula. The clock cycle in which `start_i` is sampled high counts as cycle 1. An all-zero operand finishes in cycle 4. Any other operand finishes in cycle 6 plus the number of shifts. The design is one bit per clock rather than a single-cycle leading-zero counter, so the cycle formula applies exactly. Reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `norm_iter`

## Requirements
- R1: While reset is applied and after it is released, `busy_o` and `done_o` are 0 and `result_o` and `shift_cnt_o` read 0. Applying reset in the middle of an operation returns the unit to idle.
- R2: For a non-zero operand, `result_o` at completion equals the operand shifted left by its number of leading zero bits, so bit 31 of the result is 1.
- R3: For a non-zero operand, `shift_cnt_o` at completion equals the number of leading zero bits of the operand (0 to 31).
- R4: For an all-zero operand, `result_o` and `shift_cnt_o` are 0 at completion, and `done_o` is high in cycle 4, counting the start cycle as cycle 1.
- R5: For a non-zero operand that needs s shifts, `done_o` is high in cycle 6+s, counting the start cycle as cycle 1.
- R6: An operand whose bit 31 is already 1 comes back unchanged, with a count of 0, and `done_o` is high in cycle 6.
- R7: The operand 0x00000001 gives the result 0x80000000, a count of 31, and `done_o` in cycle 37.
- R8: `done_o` is high for exactly one cycle, which is the final cycle of the operation. `busy_o` is high from the cycle after the start cycle up to and including the `done_o` cycle, and low at all other times.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running operation keeps its operand, its result and its latency, and no second operation follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| start_i | input | 1 | Start pulse; sampled only while idle |
| operand_i | input | 32 | Value to normalize, sampled together with `start_i` |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle pulse in the final cycle of an operation |
| result_o | output | 32 | Normalized value, valid from the `done_o` cycle |
| shift_cnt_o | output | 8 | Number of left shifts performed |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit count, and the cycle formula with 4 cycles for a zero operand and a base of 6 otherwise. With these values every shift count from 0 up to the worst case of 31 can be reached, along with the longest 37-cycle run. Random operands are drawn with a random number of leading zeros, so short, middle and long runs all occur. Directed cases cover the zero operand, an operand with bit 31 already set, the single low bit, a start pulse during a run, and a reset in the middle of an operation.

// File: rtl/norm_pkg.sv
package norm_pkg;

  // Control sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_POST  = 2'd3
  } norm_state_e;

endpackage

// File: rtl/norm_rst_sync.sv
module norm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/norm_ctrl.sv
module norm_ctrl
  import norm_pkg::*;
#(
  parameter int PREP_CYC = 2,
  parameter int POST_Z   = 1,
  parameter int POST_NZ  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_i,
  input  logic msb_now_i,
  input  logic msb_next_i,
  output logic load_o,
  output logic shift_o,
  output logic capture_o,
  output logic busy_o,
  output logic done_o
);

  localparam int PH_MAX0 = (PREP_CYC > POST_Z) ? PREP_CYC : POST_Z;
  localparam int PH_MAX  = (PH_MAX0 > POST_NZ) ? PH_MAX0 : POST_NZ;
  localparam int PH_W    = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

  localparam logic [PH_W-1:0] PH_PREP = PH_W'(PREP_CYC - 1);
  localparam logic [PH_W-1:0] PH_PZ   = PH_W'(POST_Z - 1);
  localparam logic [PH_W-1:0] PH_PNZ  = PH_W'(POST_NZ - 1);

  norm_state_e     state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_zero;

  assign ph_zero = (ph_q == '0);

  // Next-state process
  always_comb begin
    state_d   = state_q;
    ph_d      = ph_q;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_PREP;
          ph_d    = PH_PREP;
        end
      end
      ST_PREP: begin
        if (!ph_zero) begin
          ph_d = ph_q - 1'b1;
        end else if (zero_i) begin
          capture_o = 1'b1;
          state_d   = ST_POST;
          ph_d      = PH_PZ;
        end else if (msb_now_i) begin
          capture_o = 1'b1;
          state_d   = ST_POST;
          ph_d      = PH_PNZ;
        end else begin
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        shift_o = 1'b1;
        if (msb_next_i) begin
          capture_o = 1'b1;
          state_d   = ST_POST;
          ph_d      = PH_PNZ;
        end
      end
      ST_POST: begin
        if (ph_zero) begin
          state_d = ST_IDLE;
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_POST) && ph_zero;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

endmodule

// File: rtl/norm_datapath.sv
module norm_datapath #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              zero_o,
  output logic              msb_now_o,
  output logic              msb_next_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [DATA_W-1:0] work_q, work_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] res_q;
  logic [CNT_W-1:0]  rcnt_q;
  logic              work_en;

  // Next-state process for the working word and running count
  always_comb begin
    work_d = work_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      work_d = operand_i;
      cnt_d  = '0;
    end else if (shift_i) begin
      work_d = {work_q[DATA_W-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  assign work_en = load_i | shift_i;

  // Register processes with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      cnt_q  <= '0;
    end else if (work_en) begin
      work_q <= work_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      rcnt_q <= '0;
    end else if (capture_i) begin
      res_q  <= work_d;
      rcnt_q <= cnt_d;
    end
  end

  assign zero_o     = (work_q == '0);
  assign msb_now_o  = work_q[DATA_W-1];
  assign msb_next_o = work_q[DATA_W-2];
  assign result_o   = res_q;
  assign count_o    = rcnt_q;

  // R2
  no_lost_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !work_q[DATA_W-1]);
  // R3
  shift_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/norm_iter.sv
module norm_iter #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 8,
  parameter int CYC_ZERO = 4,
  parameter int CYC_BASE = 6,
  parameter int PREP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CNT_W-1:0]  shift_cnt_o
);

  localparam int POST_Z  = CYC_ZERO - 1 - PREP_CYC;
  localparam int POST_NZ = CYC_BASE - 1 - PREP_CYC;

  logic rst_sync_n;
  logic load, shift, capture;
  logic zero, msb_now, msb_next;

  norm_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  norm_ctrl #(
    .PREP_CYC (PREP_CYC),
    .POST_Z   (POST_Z),
    .POST_NZ  (POST_NZ)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .zero_i     (zero),
    .msb_now_i  (msb_now),
    .msb_next_i (msb_next),
    .load_o     (load),
    .shift_o    (shift),
    .capture_o  (capture),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  norm_datapath #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load),
    .shift_i    (shift),
    .capture_i  (capture),
    .operand_i  (operand_i),
    .zero_o     (zero),
    .msb_now_o  (msb_now),
    .msb_next_o (msb_next),
    .result_o   (result_o),
    .count_o    (shift_cnt_o)
  );

  // R2 R4
  result_form_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (result_o[DATA_W-1] || (result_o == '0 && shift_cnt_o == '0)));
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (shift_cnt_o <= CNT_W'(DATA_W - 1)));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_sync_n |=> (!busy_o && !done_o && result_o == '0));

endmodule

// File: tb/norm_iter_tb_top.sv
`timescale 1ns/1ps
module norm_iter_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] operand;
  logic        busy, done;
  logic [31:0] result;
  logic [7:0]  cnt;

  int errors = 0;
  int checks = 0;

  norm_iter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .operand_i   (operand),
    .busy_o      (busy),
    .done_o      (done),
    .result_o    (result),
    .shift_cnt_o (cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int lead_zeros(logic [31:0] v);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return 0;
  endfunction

  function automatic int exp_cycles(logic [31:0] v);
    return (v == 0) ? 4 : 6 + lead_zeros(v);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One operation; inj puts a start pulse with another operand in cycle 3
  task automatic run_op(logic [31:0] op, bit inj, string lat_tag);
    int k;
    logic [31:0] exp_res;
    exp_res = (op == 0) ? 32'd0 : (op << lead_zeros(op));
    @(negedge clk);
    chk("R8 idle before start", {31'd0, busy}, 32'd0);
    start   = 1'b1;
    operand = op;
    @(negedge clk);
    start = 1'b0;
    k = 2;
    while (k < 60) begin
      chk("R8 busy during run", {31'd0, busy}, 32'd1);
      if (done) break;
      start = (inj && k == 3);
      if (inj && k == 3) operand = ~op;
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    chk(lat_tag, k, exp_cycles(op));
    chk(inj ? "R9 result with extra start" : "R2 result", result, exp_res);
    chk(inj ? "R9 count with extra start" : "R3 count", {24'd0, cnt}, lead_zeros(op));
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk(inj ? "R9 no second run" : "R8 busy low after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] op;
    void'($urandom(32'd2024));
    rst_n   = 1'b0;
    start   = 1'b0;
    operand = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 result after reset", result, 32'd0);
    chk("R1 count after reset", {24'd0, cnt}, 32'd0);

    run_op(32'h0000_0000, 1'b0, "R4 zero latency");
    run_op(32'h8000_0000, 1'b0, "R6 msb set latency");
    run_op(32'hFFFF_FFFF, 1'b0, "R6 all ones latency");
    run_op(32'h0000_0001, 1'b0, "R7 max latency");
    run_op(32'h4000_0000, 1'b0, "R5 one shift latency");
    run_op(32'h0001_2345, 1'b1, "R9 latency with extra start");
    run_op(32'h0000_0000, 1'b1, "R9 zero latency with extra start");

    for (int i = 0; i < 40; i++) begin
      op = ($urandom() | 32'h8000_0000) >> ($urandom() % 32);
      run_op(op, 1'b0, "R5 random latency");
    end

    // Reset in the middle of an operation
    @(negedge clk);
    start   = 1'b1;
    operand = 32'h0000_0003;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after mid-run reset", {31'd0, busy}, 32'd0);
    chk("R1 result after mid-run reset", result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 stays idle", {31'd0, busy}, 32'd0);
    run_op(32'h0000_0003, 1'b0, "R5 after reset latency");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule